// File: doc/BRIEF.md
# Adaptive Two-Error BCH Decoder

This block corrects up to two flipped bits in a 274-bit codeword read from a memory array. The codeword is a shortened binary BCH code over GF(2^9) with 256 data bits and 18 check bits. The block has no clock and no state: the codeword goes in, and the corrected 256 data bits, a count of the corrected bits and a flag for words it cannot repair come out through logic alone. It is meant to sit directly in a read path between the sense stage and the page latch, where the extra delay must stay small.

Two odd syndromes are formed by fixed XOR trees. Their combination `S1^3 + S3` gives the error weight. A quadratic locator `S1*X^2 + S1^2*X + (S1^3 + S3)` needs no division and has its roots at `X = alpha^j` for each bad position j. All 274 positions are tested side by side. The single-error test is the part of that locator that does not use the weight term, so it can resolve as soon as S1 is known. The weight term then selects either the one-flip result or the two-flip result.

Top module: `bch2_adaptive_decoder`

## Requirements
- R1: With an all-zero received word, `dataOut` is zero, `errCount` is 0 and `uncorrectable` is 0.
- R2: Codeword bit j is the coefficient of x^j. The 18 check bits hold positions 17..0 and the data holds 273..18, with `dataOut[i]` = position i+18. A valid codeword is `data*x^18 + (data*x^18 mod g)`, where `g = m1*m3` is over GF(2), `m1 = x^9+x^4+1` is the field polynomial and m3 is the minimal polynomial of alpha^3. A valid codeword gives back its data with count 0.
- R3: A single flipped bit at any of the 274 positions is repaired, and `errCount` is 1.
- R4: Any two flipped bits among the 274 positions are repaired, and `errCount` is 2.
- R5: When the flipped bits are all in the check positions 17..0, `dataOut` equals the sent data and `errCount` still reports their number.
- R6: A received word with S1 = 0 and S3 != 0 raises `uncorrectable`.
- R7: A received word with S1 != 0 and a nonzero syndrome pair that does not match one or two flips inside the 274 positions raises `uncorrectable`. This includes the case where the weight term is nonzero and fewer than two roots are found.
- R8: While `uncorrectable` is 1, `dataOut` equals received positions 273..18 exactly and `errCount` is 0.
- R9: `dataOut` never differs from received positions 273..18 in more bits than `errCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rxWord | input | 274 | Received codeword, bit j is position j |
| dataOut | output | 256 | Corrected data, positions 273..18 |
| errCount | output | 2 | Number of bits repaired: 0, 1 or 2 |
| uncorrectable | output | 1 | Set when the syndromes fit no pattern of two or fewer flips |

## Verification
The hardest state to reach from the ports is S1 = 0 with S3 != 0. No one- or two-bit error can produce it. The bench therefore searches its own log table for three positions whose field elements sum to zero and that all lie below 274, and flips those. The case of a nonzero weight term with too few roots is reached the same way, with random three-bit errors. For each of these, an independent brute-force search over positions decides whether a one- or two-flip explanation exists, so both miscorrections and refusals are predicted.

// File: rtl/bch2_pkg.sv
package bch2_pkg;

  // strobes from control into the datapath output mux
  typedef struct packed {
    logic useSec;
    logic useDec;
  } fixStrobe_t;

  // syndrome and root facts reported by the datapath
  typedef struct packed {
    logic s1Zero;
    logic s3Zero;
    logic keyZero;
    logic secFound;
    logic decPair;
  } synStatus_t;

  // multiply by x modulo the field polynomial (low bits of poly given)
  function automatic logic [15:0] mul_x(input logic [15:0] a, input logic [15:0] poly,
                                        input int width);
    logic [15:0] mask;
    logic        top;
    mask = (16'(1) << width) - 16'(1);
    top  = a[width-1];
    mul_x = (a << 1) & mask;
    if (top) mul_x = mul_x ^ poly;
  endfunction

  // general field product, Horner over the bits of b
  function automatic logic [15:0] gf_mul(input logic [15:0] a, input logic [15:0] b,
                                         input logic [15:0] poly, input int width);
    logic [15:0] acc;
    acc = '0;
    for (int i = 15; i >= 0; i--) begin
      if (i < width) begin
        acc = mul_x(acc, poly, width);
        if (b[i]) acc = acc ^ a;
      end
    end
    gf_mul = acc;
  endfunction

  // alpha raised to a small exponent
  function automatic logic [15:0] alpha_pow(input int e, input logic [15:0] poly,
                                            input int width);
    logic [15:0] p;
    p = 16'd1;
    for (int i = 0; i < e; i++) p = mul_x(p, poly, width);
    alpha_pow = p;
  endfunction

endpackage

// File: rtl/bch2_syndrome_tree.sv
module bch2_syndrome_tree
  import bch2_pkg::*;
#(
  parameter int CW_LEN     = 274,
  parameter int FIELD_M    = 9,
  parameter int FIELD_POLY = 'h011,
  parameter int STEP       = 1
) (
  input  logic [CW_LEN-1:0]  rxWord,
  output logic [FIELD_M-1:0] synVal
);

  localparam logic [15:0] POLY16    = 16'(FIELD_POLY);
  localparam logic [15:0] STEP_ELEM = alpha_pow(STEP, POLY16, FIELD_M);

  // positions whose alpha^(STEP*j) has bit bitSel set
  function automatic logic [CW_LEN-1:0] tapMask(input int bitSel);
    logic [15:0]       p;
    logic [CW_LEN-1:0] m;
    p = 16'd1;
    m = '0;
    for (int j = 0; j < CW_LEN; j++) begin
      m[j] = p[bitSel];
      p    = gf_mul(p, STEP_ELEM, POLY16, FIELD_M);
    end
    tapMask = m;
  endfunction

  for (genvar b = 0; b < FIELD_M; b++) begin : g_bit
    localparam logic [CW_LEN-1:0] TAPS = tapMask(b);
    assign synVal[b] = ^(rxWord & TAPS);
  end

endmodule

// File: rtl/bch2_root_search.sv
module bch2_root_search
  import bch2_pkg::*;
#(
  parameter int CW_LEN     = 274,
  parameter int FIELD_M    = 9,
  parameter int FIELD_POLY = 'h011
) (
  input  logic [FIELD_M-1:0] synOne,
  input  logic [FIELD_M-1:0] synOneSq,
  input  logic [FIELD_M-1:0] weightKey,
  output logic [CW_LEN-1:0]  secHits,
  output logic [CW_LEN-1:0]  decHits
);

  localparam logic [15:0] POLY16 = 16'(FIELD_POLY);

  logic s1Nonzero;
  assign s1Nonzero = |synOne;

  // locator S1*X^2 + S1^2*X + key at X = alpha^j; the key-free part
  // vanishes exactly when X equals S1, which is the one-flip test
  for (genvar j = 0; j < CW_LEN; j++) begin : g_pos
    localparam logic [15:0] LOC    = alpha_pow(j, POLY16, FIELD_M);
    localparam logic [15:0] LOC_SQ = gf_mul(LOC, LOC, POLY16, FIELD_M);
    logic [FIELD_M-1:0] partial;
    assign partial = FIELD_M'(gf_mul(16'(synOne), LOC_SQ, POLY16, FIELD_M) ^
                              gf_mul(16'(synOneSq), LOC, POLY16, FIELD_M));
    assign secHits[j] = s1Nonzero && (partial == '0);
    assign decHits[j] = (partial == weightKey);
  end

  always_comb begin
    p_sec_onehot_r3: assert ($onehot0(secHits))
      else $error("one-flip search marked several positions");
  end

endmodule

// File: rtl/bch2_datapath.sv
module bch2_datapath
  import bch2_pkg::*;
#(
  parameter int CW_LEN     = 274,
  parameter int DATA_LEN   = 256,
  parameter int FIELD_M    = 9,
  parameter int FIELD_POLY = 'h011
) (
  input  logic [CW_LEN-1:0]   rxWord,
  input  fixStrobe_t          strobe,
  output synStatus_t          status,
  output logic [DATA_LEN-1:0] dataOut
);

  localparam int          PAR_LEN = CW_LEN - DATA_LEN;
  localparam logic [15:0] POLY16  = 16'(FIELD_POLY);

  logic [FIELD_M-1:0] synOne, synThree, synOneSq, synOneCube, weightKey;
  logic [CW_LEN-1:0]  secHits, decHits, fixMask;

  bch2_syndrome_tree #(.CW_LEN(CW_LEN), .FIELD_M(FIELD_M), .FIELD_POLY(FIELD_POLY), .STEP(1))
    u_synOne (.rxWord(rxWord), .synVal(synOne));

  bch2_syndrome_tree #(.CW_LEN(CW_LEN), .FIELD_M(FIELD_M), .FIELD_POLY(FIELD_POLY), .STEP(3))
    u_synThree (.rxWord(rxWord), .synVal(synThree));

  assign synOneSq   = FIELD_M'(gf_mul(16'(synOne), 16'(synOne), POLY16, FIELD_M));
  assign synOneCube = FIELD_M'(gf_mul(16'(synOneSq), 16'(synOne), POLY16, FIELD_M));
  assign weightKey  = synOneCube ^ synThree;

  bch2_root_search #(.CW_LEN(CW_LEN), .FIELD_M(FIELD_M), .FIELD_POLY(FIELD_POLY))
    u_search (
      .synOne   (synOne),
      .synOneSq (synOneSq),
      .weightKey(weightKey),
      .secHits  (secHits),
      .decHits  (decHits)
    );

  always_comb begin
    status.s1Zero   = (synOne == '0);
    status.s3Zero   = (synThree == '0);
    status.keyZero  = (weightKey == '0);
    status.secFound = |secHits;
    status.decPair  = (decHits != '0) && ((decHits & (decHits - CW_LEN'(1))) != '0);
  end

  always_comb begin
    if (strobe.useDec)      fixMask = decHits;
    else if (strobe.useSec) fixMask = secHits;
    else                    fixMask = '0;
  end

  assign dataOut = rxWord[CW_LEN-1:PAR_LEN] ^ fixMask[CW_LEN-1:PAR_LEN];

  always_comb begin
    if (strobe.useSec) begin
      p_sec_single_r3: assert ($countones(fixMask) == 1)
        else $error("one-flip path chosen without a single root");
    end
    if (strobe.useDec) begin
      p_dec_pair_r4: assert ($countones(fixMask) == 2)
        else $error("two-flip path chosen without two roots");
    end
    if (!strobe.useSec && !strobe.useDec) begin
      p_pass_r8: assert (dataOut == rxWord[CW_LEN-1:PAR_LEN])
        else $error("data changed while no correction selected");
    end
  end

endmodule

// File: rtl/bch2_control.sv
module bch2_control
  import bch2_pkg::*;
(
  input  synStatus_t status,
  output fixStrobe_t strobe,
  output logic [1:0] errCount,
  output logic       uncorrectable
);

  always_comb begin
    strobe        = '0;
    errCount      = 2'd0;
    uncorrectable = 1'b0;
    if (status.s1Zero) begin
      // S1 zero with S3 set fits no pattern of weight two or less
      uncorrectable = !status.s3Zero;
    end else if (status.keyZero) begin
      if (status.secFound) begin
        strobe.useSec = 1'b1;
        errCount      = 2'd1;
      end else begin
        uncorrectable = 1'b1;
      end
    end else if (status.decPair) begin
      strobe.useDec = 1'b1;
      errCount      = 2'd2;
    end else begin
      uncorrectable = 1'b1;
    end
  end

  always_comb begin
    if (uncorrectable) begin
      p_unc_count_r8: assert (errCount == 2'd0 && !strobe.useSec && !strobe.useDec)
        else $error("refused word still reports a correction");
    end
  end

endmodule

// File: rtl/bch2_adaptive_decoder.sv
module bch2_adaptive_decoder
  import bch2_pkg::*;
#(
  parameter int CW_LEN     = 274,
  parameter int DATA_LEN   = 256,
  parameter int FIELD_M    = 9,
  parameter int FIELD_POLY = 'h011
) (
  input  logic [CW_LEN-1:0]   rxWord,
  output logic [DATA_LEN-1:0] dataOut,
  output logic [1:0]          errCount,
  output logic                uncorrectable
);

  fixStrobe_t strobe;
  synStatus_t status;

  bch2_datapath #(
    .CW_LEN(CW_LEN), .DATA_LEN(DATA_LEN), .FIELD_M(FIELD_M), .FIELD_POLY(FIELD_POLY)
  ) u_datapath (
    .rxWord (rxWord),
    .strobe (strobe),
    .status (status),
    .dataOut(dataOut)
  );

  bch2_control u_control (
    .status       (status),
    .strobe       (strobe),
    .errCount     (errCount),
    .uncorrectable(uncorrectable)
  );

endmodule

// File: tb/bch2_adaptive_decoder_test.sv
`timescale 1ns/1ps
module bch2_adaptive_decoder_test;

  localparam int CW = 274;
  localparam int DL = 256;
  localparam int PL = CW - DL;
  localparam int ORD = 511;

  typedef struct {
    logic [DL-1:0] data;
    logic [1:0]    cnt;
    logic          unc;
    logic [DL-1:0] rxData;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] rxWord = '0;
  logic [DL-1:0] dataOut;
  logic [1:0]    errCount;
  logic          uncorrectable;

  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];

  logic [8:0]  expTab[0:ORD-1];
  int          logTab[0:511];
  logic [18:0] genPoly;

  always #2.5 clk = ~clk;

  bch2_adaptive_decoder uut (
    .rxWord(rxWord), .dataOut(dataOut), .errCount(errCount), .uncorrectable(uncorrectable)
  );

  function automatic logic [8:0] bMul(input logic [8:0] a, input logic [8:0] b);
    logic [8:0] acc = '0;
    for (int i = 8; i >= 0; i--) begin
      acc = acc[8] ? ({acc[7:0], 1'b0} ^ 9'h011) : {acc[7:0], 1'b0};
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [8:0] cube(input logic [8:0] a);
    return bMul(bMul(a, a), a);
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DL-1:0] d);
    logic [PL-1:0] rem = '0;
    for (int i = DL - 1; i >= 0; i--) begin
      logic fb;
      fb  = d[i] ^ rem[PL-1];
      rem = {rem[PL-2:0], 1'b0};
      if (fb) rem = rem ^ genPoly[PL-1:0];
    end
    return {d, rem};
  endfunction

  function automatic logic [CW-1:0] flip(input logic [CW-1:0] w, input int p);
    logic [CW-1:0] r = w;
    r[p] = ~r[p];
    return r;
  endfunction

  function automatic logic [DL-1:0] rndData();
    logic [DL-1:0] d;
    for (int i = 0; i < DL / 32; i++) d[i*32 +: 32] = $urandom();
    return d;
  endfunction

  // brute-force reference over the positions, from the requirements
  task automatic refModel(input logic [CW-1:0] rx, output exp_t e, output logic [8:0] s1o);
    logic [8:0]    s1 = '0, s3 = '0;
    logic [CW-1:0] fixed = rx;
    logic          found = 1'b0;
    e.cnt = 2'd0;
    e.unc = 1'b0;
    for (int j = 0; j < CW; j++) if (rx[j]) begin
      s1 = s1 ^ expTab[j];
      s3 = s3 ^ expTab[(3 * j) % ORD];
    end
    if (s1 == 0 && s3 == 0) begin
      found = 1'b1;
    end else if (s1 == 0) begin
      e.unc = 1'b1;
    end else begin
      if (logTab[s1] < CW && cube(s1) == s3) begin
        fixed[logTab[s1]] = ~fixed[logTab[s1]];
        e.cnt = 2'd1;
        found = 1'b1;
      end
      for (int j = 0; j < CW; j++) if (!found) begin
        logic [8:0] x2;
        x2 = s1 ^ expTab[j];
        if (x2 != 0 && logTab[x2] > j && logTab[x2] < CW &&
            (cube(expTab[j]) ^ cube(x2)) == s3) begin
          fixed[j] = ~fixed[j];
          fixed[logTab[x2]] = ~fixed[logTab[x2]];
          e.cnt = 2'd2;
          found = 1'b1;
        end
      end
      if (!found) e.unc = 1'b1;
    end
    e.data   = fixed[CW-1:PL];
    e.rxData = rx[CW-1:PL];
    s1o      = s1;
  endtask

  task automatic drive(input logic [CW-1:0] w, input logic [DL-1:0] d, input logic [1:0] c,
                       input logic u, input string tag);
    exp_t e;
    e.data = d; e.cnt = c; e.unc = u; e.rxData = w[CW-1:PL]; e.tag = tag;
    @(negedge clk);
    rxWord = w;
    sb.push_back(e);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: outputs settle half a cycle after the negedge drive
  always @(posedge clk) begin
    exp_t it;
    int   diffs;
    if (!rst && sb.size() != 0) begin
      it = sb.pop_front();
      checks++;
      if (dataOut !== it.data || errCount !== it.cnt || uncorrectable !== it.unc) begin
        errors++;
        $display("FAIL %s data=%h exp=%h count=%0d exp=%0d unc=%0b exp=%0b",
                 it.tag, dataOut, it.data, errCount, it.cnt, uncorrectable, it.unc);
      end
      checks++;
      diffs = $countones(dataOut ^ it.rxData);
      if (diffs > int'(errCount)) begin
        errors++;
        $display("FAIL R9 changed bits=%0d expected at most %0d", diffs, errCount);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired with %0d items pending, expected 0", sb.size());
    finishRun();
  end

  initial begin
    logic [8:0]    pc[0:9];
    logic [9:0]    m3;
    logic [DL-1:0] d;
    logic [CW-1:0] cw;
    exp_t          e;
    logic [8:0]    s1;
    int            e3;
    int            r6Hits;
    int            r7Hits;

    // field tables
    expTab[0] = 9'd1;
    for (int i = 1; i < ORD; i++)
      expTab[i] = expTab[i-1][8] ? ({expTab[i-1][7:0], 1'b0} ^ 9'h011) : {expTab[i-1][7:0], 1'b0};
    for (int i = 0; i < 512; i++) logTab[i] = ORD;
    for (int i = 0; i < ORD; i++) logTab[expTab[i]] = i;

    // minimal polynomial of alpha^3, then generator m1*m3
    pc[0] = 9'd1;
    for (int k = 1; k < 10; k++) pc[k] = '0;
    e3 = 3;
    for (int i = 0; i < 9; i++) begin
      for (int k = 9; k >= 1; k--) pc[k] = pc[k-1] ^ bMul(pc[k], expTab[e3]);
      pc[0] = bMul(pc[0], expTab[e3]);
      e3 = (e3 * 2) % ORD;
    end
    for (int k = 0; k < 10; k++) m3[k] = pc[k][0];
    genPoly = '0;
    for (int a = 0; a < 10; a++)
      if (a == 9 || a == 4 || a == 0) genPoly = genPoly ^ (19'(m3) << a);

    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1: all-zero word
    drive('0, '0, 2'd0, 1'b0, "R1 zero word");

    // R2: clean codewords
    drive(encode({DL{1'b1}}), {DL{1'b1}}, 2'd0, 1'b0, "R2 all-ones data");
    for (int n = 0; n < 6; n++) begin
      d = rndData();
      drive(encode(d), d, 2'd0, 1'b0, "R2 clean codeword");
    end

    // R3 and R5: every single position on two words
    for (int n = 0; n < 2; n++) begin
      d  = rndData();
      cw = encode(d);
      for (int p = 0; p < CW; p++)
        drive(flip(cw, p), d, 2'd1, 1'b0, (p < PL) ? "R5 single check-bit" : "R3 single");
    end

    // R4 and R5: double errors at edges and at random
    d  = rndData();
    cw = encode(d);
    drive(flip(flip(cw, 0), 273), d, 2'd2, 1'b0, "R4 ends");
    drive(flip(flip(cw, 0), 1), d, 2'd2, 1'b0, "R5 two low check bits");
    drive(flip(flip(cw, 272), 273), d, 2'd2, 1'b0, "R4 top pair");
    drive(flip(flip(cw, 17), 18), d, 2'd2, 1'b0, "R4 field seam");
    drive(flip(flip(cw, 5), 12), d, 2'd2, 1'b0, "R5 two check bits");
    for (int n = 0; n < 300; n++) begin
      int a, b;
      d  = rndData();
      cw = encode(d);
      a  = $urandom_range(CW - 1);
      do b = $urandom_range(CW - 1); while (b == a);
      drive(flip(flip(cw, a), b), d, 2'd2, 1'b0, "R4 random pair");
    end

    // R6 and R8: three flips whose alpha powers cancel, so S1 = 0
    r6Hits = 0;
    d  = rndData();
    cw = encode(d);
    for (int a = 0; a < 30; a++) for (int b = a + 1; b < 60; b++) begin
      int c;
      c = logTab[expTab[a] ^ expTab[b]];
      if (r6Hits < 4 && c < CW && c != a && c != b &&
          (cube(expTab[a]) ^ cube(expTab[b]) ^ cube(expTab[c])) != 0) begin
        cw = flip(flip(flip(encode(d), a), b), c);
        drive(cw, cw[CW-1:PL], 2'd0, 1'b1, "R6 R8 S1 zero");
        r6Hits++;
      end
    end
    if (r6Hits == 0) begin
      checks++; errors++;
      $display("FAIL R6 cancelling triples found=0 expected>0");
    end

    // R7 and R8: random triple errors judged by the reference search
    r7Hits = 0;
    for (int n = 0; n < 220 || (r7Hits == 0 && n < 3000); n++) begin
      int a, b, c;
      d = rndData();
      a = $urandom_range(CW - 1);
      do b = $urandom_range(CW - 1); while (b == a);
      do c = $urandom_range(CW - 1); while (c == a || c == b);
      cw = flip(flip(flip(encode(d), a), b), c);
      refModel(cw, e, s1);
      if (e.unc && s1 != 0) r7Hits++;
      if (n < 220 || (e.unc && s1 != 0))
        drive(cw, e.data, e.cnt, e.unc, e.unc ? "R7 R8 refused" : "R4 triple miscorrect");
    end
    if (r7Hits == 0) begin
      checks++; errors++;
      $display("FAIL R7 refused triples found=0 expected>0");
    end

    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule